// File: doc/BRIEF.md
# Register-Mapped GPIO Pin Bank

This block gives software control over a bank of general-purpose pins through a simple 32-bit register bus. Each pin has two configuration words of its own. The first word holds the output level, the sampled input level, the direction and the usage select. The second word holds an input-sense disable and a weak-pull selection. Three shared bitmap words record, one bit per pin, whether firmware has kept the pin for itself.

The bank drives the pad output level and output enable for every pin. It exports the weak-pull selection as control bits. Pad inputs pass through a two-flop synchronizer before they appear in the input-level bit. The bus write takes effect at the clock edge on which `bus_we` is high. A read is combinational from `bus_addr`.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin's first word reads 0x00000005 (input, usage GPIO, output level 0) and its second word reads 0x00000004 (sense disabled, pull 0). No pad output enable is set.
- R2: Ownership bitmap words sit at byte offsets 0x00, 0x04 and 0x08. Pin p is bit p mod 32 of the word at 4*(p/32). A bit at 0 marks the pin as firmware-owned and a 1 marks it as free. The reset value comes from the parameter `RSV_INIT`. The bits are writable, and bits at or above the pin count read 0 and ignore writes.
- R3: Pin p's first word is at 0x100 + 8*p. Bit 31 is the output level, bit 2 is the direction (0 output, 1 input) and bits [1:0] are the usage (0 native, 1 GPIO, 2 and 3 stored but not GPIO). All other bits except bit 30 read 0.
- R4: Pin p's second word is at 0x104 + 8*p. Bit 2 disables input sensing and bits [1:0] are the weak-pull option. The pull option appears on `pull_sel[2p+1:2p]`, and all other bits read 0.
- R5: `pad_oe[p]` is 1 exactly when pin p's usage is 1 and its direction is 0. `pad_out[p]` equals pin p's output-level bit.
- R6: Bit 30 of the first word is read-only and shows `pad_in[p]` through a two-flop synchronizer. A pad change shows after two rising clock edges and does not show after one. Writes to bit 30 have no effect.
- R7: While input sensing is disabled, bit 30 of the pin's first word reads 0 whatever the pad level.
- R8: Unmapped offsets read 0 and ignore writes. These include offsets with bits [1:0] not zero, offsets between the bitmap and 0x100, and offsets at or above 0x100 + 8*pin count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| pull_sel | output | 2*NUM_PINS | Weak-pull option, two bits per pin |

## Verification
The assertions run on every cycle. They check that the output enable follows a first-word write one cycle later, and that a write setting sense-disable forces the input bit to 0. They also check that the pull outputs follow a second-word write, that the synchronizer output trails its input by exactly two cycles, and that unmapped or unused high bitmap bits read as zero. Some behaviour shows only through the bench's scenarios: the address arithmetic for every pin and word, the parameter-driven bitmap reset, the rejection of writes to the read-only and unused bits, and the exact edge at which a pad change first becomes readable.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int CFG_BASE   = 'h100;
    localparam int CFG_STRIDE = 8;

    localparam int BIT_OUT    = 31;
    localparam int BIT_IN     = 30;
    localparam int BIT_DIR    = 2;
    localparam int BIT_SENSEN = 2;

    typedef enum logic [1:0] {
        USE_NATIVE = 2'd0,
        USE_GPIO   = 2'd1,
        USE_ALT2   = 2'd2,
        USE_ALT3   = 2'd3
    } usage_e;

    typedef struct packed {
        logic   out_lvl;
        logic   dir_in;
        usage_e usage;
    } ctl_a_t;

    typedef struct packed {
        logic       sense_off;
        logic [1:0] pull;
    } ctl_b_t;

    localparam ctl_a_t CTL_A_RST = '{out_lvl: 1'b0, dir_in: 1'b1, usage: USE_GPIO};
    localparam ctl_b_t CTL_B_RST = '{sense_off: 1'b1, pull: 2'b00};

    function automatic logic [31:0] pack_a(ctl_a_t c, logic in_lvl);
        logic [31:0] w;
        w          = '0;
        w[BIT_OUT] = c.out_lvl;
        w[BIT_IN]  = in_lvl;
        w[BIT_DIR] = c.dir_in;
        w[1:0]     = c.usage;
        return w;
    endfunction

    function automatic logic [31:0] pack_b(ctl_b_t c);
        logic [31:0] w;
        w             = '0;
        w[BIT_SENSEN] = c.sense_off;
        w[1:0]        = c.pull;
        return w;
    endfunction

    function automatic logic drives_pad(ctl_a_t c);
        return (c.usage == USE_GPIO) && !c.dir_in;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [1:0]   primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
            primed <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
            if (primed != 2'd3) primed <= primed + 2'd1;
        end
    end

    // R6: output trails the input by exactly two edges
    a_r6_two_stage: assert property (@(posedge clk) disable iff (rst)
        (primed >= 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_a,
    input  logic        wr_b,
    input  logic [31:0] wdata,
    input  logic        pin_sync,
    output logic [31:0] word_a,
    output logic [31:0] word_b,
    output logic        pin_out,
    output logic        pin_oe,
    output logic [1:0]  pin_pull
);
    ctl_a_t ctl_a;
    ctl_b_t ctl_b;
    logic   in_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_a <= CTL_A_RST;
            ctl_b <= CTL_B_RST;
        end else begin
            if (wr_a) begin
                ctl_a.out_lvl <= wdata[BIT_OUT];
                ctl_a.dir_in  <= wdata[BIT_DIR];
                ctl_a.usage   <= usage_e'(wdata[1:0]);
            end
            if (wr_b) begin
                ctl_b.sense_off <= wdata[BIT_SENSEN];
                ctl_b.pull      <= wdata[1:0];
            end
        end
    end

    always_comb begin
        in_lvl   = pin_sync & ~ctl_b.sense_off;
        word_a   = pack_a(ctl_a, in_lvl);
        word_b   = pack_b(ctl_b);
        pin_out  = ctl_a.out_lvl;
        pin_oe   = drives_pad(ctl_a);
        pin_pull = ctl_b.pull;
    end

    // R5: output enable follows the written usage and direction
    a_r5_oe_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_a |=> (pin_oe == ($past(wdata[1:0]) == 2'd1 && !$past(wdata[2]))));

    // R7: setting sense-disable silences the input bit
    a_r7_sense_off_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_b && wdata[2]) |=> (word_a[30] == 1'b0));

    // R4: pull outputs follow a second-word write
    a_r4_pull_follows: assert property (@(posedge clk) disable iff (rst)
        wr_b |=> (pin_pull == $past(wdata[1:0])));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int                  NUM_PINS = 95,
    parameter int                  ADDR_W   = 12,
    parameter logic [NUM_PINS-1:0] RSV_INIT = '1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [2*NUM_PINS-1:0] pull_sel
);
    localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
    localparam int BMAP_W    = NUM_WORDS * 32;
    localparam int IDX_W     = ADDR_W - 3;
    localparam int SEL_W     = $clog2(NUM_PINS);
    localparam int CFG_END   = CFG_BASE + CFG_STRIDE * NUM_PINS;
    localparam logic [BMAP_W-1:0] VALID = BMAP_W'({NUM_PINS{1'b1}});

    logic [BMAP_W-1:0]   rsv;
    logic [NUM_PINS-1:0] pad_sync;
    logic [31:0]         wa_arr [NUM_PINS];
    logic [31:0]         wb_arr [NUM_PINS];

    logic              aligned, bmap_hit, cfg_hit, cfg_hi;
    logic [ADDR_W-3:0] bmap_word;
    logic [ADDR_W-1:0] cfg_off;
    logic [IDX_W-1:0]  cfg_pin;
    logic [SEL_W-1:0]  pin_sel;

    always_comb begin
        aligned   = (bus_addr[1:0] == 2'b00);
        bmap_word = bus_addr[ADDR_W-1:2];
        bmap_hit  = aligned && (bus_addr < ADDR_W'(4 * NUM_WORDS));
        cfg_off   = bus_addr - ADDR_W'(CFG_BASE);
        cfg_pin   = cfg_off[ADDR_W-1:3];
        cfg_hi    = cfg_off[2];
        cfg_hit   = aligned && (bus_addr >= ADDR_W'(CFG_BASE))
                    && (cfg_pin < IDX_W'(NUM_PINS));
        pin_sel   = cfg_pin[SEL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsv <= BMAP_W'(RSV_INIT);
        end else if (bus_we && bmap_hit) begin
            for (int k = 0; k < NUM_WORDS; k++) begin
                if (bmap_word == (ADDR_W-2)'(k))
                    rsv[k*32 +: 32] <= bus_wdata & VALID[k*32 +: 32];
            end
        end
    end

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic sel;
        assign sel = bus_we && cfg_hit && (pin_sel == SEL_W'(i));
        gpio_pin_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .wr_a     (sel && !cfg_hi),
            .wr_b     (sel && cfg_hi),
            .wdata    (bus_wdata),
            .pin_sync (pad_sync[i]),
            .word_a   (wa_arr[i]),
            .word_b   (wb_arr[i]),
            .pin_out  (pad_out[i]),
            .pin_oe   (pad_oe[i]),
            .pin_pull (pull_sel[2*i +: 2])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bmap_hit)
            bus_rdata = rsv[int'(bmap_word)*32 +: 32];
        else if (cfg_hit)
            bus_rdata = cfg_hi ? wb_arr[pin_sel] : wa_arr[pin_sel];
    end

    // R8: offsets past the last configuration word read zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= ADDR_W'(CFG_END)) |-> (bus_rdata == 32'd0));

    // R2: the unused top bit of the last bitmap word never reads 1
    if (NUM_PINS % 32 != 0) begin : g_top_chk
        a_r2_top_bits_zero: assert property (@(posedge clk) disable iff (rst)
            (bus_addr == ADDR_W'(4 * (NUM_WORDS - 1))) |-> (bus_rdata[31] == 1'b0));
    end

endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 95;
    localparam int AW = 12;
    localparam logic [NP-1:0] RSV = {31'h2A5A5A5A, 32'hF0F0F0F0, 32'h12345678};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_out, pad_oe;
    logic [2*NP-1:0] pull_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank #(.NUM_PINS(NP), .ADDR_W(AW), .RSV_INIT(RSV)) dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_sel(pull_sel)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state of every pin
        check("R1 oe", 32'(pad_oe != '0), 32'd0);
        for (int p = 0; p < NP; p++) begin
            rd('h100 + 8*p, v); check("R1 word a", v, 32'h5);
            rd('h104 + 8*p, v); check("R1 word b", v, 32'h4);
        end

        // R2: bitmap reset from parameter, per pin bit position
        rd('h00, v); check("R2 word0", v, 32'h12345678);
        rd('h04, v); check("R2 word1", v, 32'hF0F0F0F0);
        rd('h08, v); check("R2 word2", v, 32'h2A5A5A5A);
        for (int p = 0; p < NP; p++) begin
            rd(4*(p/32), v); check("R2 pin bit", 32'(v[p%32]), 32'(RSV[p]));
        end
        wr('h08, 32'hFFFFFFFF); rd('h08, v); check("R2 top bit", v, 32'h7FFFFFFF);
        wr('h00, 32'h0);        rd('h00, v); check("R2 write", v, 32'h0);

        // R3 R5 R6: first word fields, junk and read-only bits dropped
        for (int p = 0; p < NP; p++) begin
            logic       o = p[0];
            logic [1:0] u = 2'(p % 4);
            logic       di = ((p / 4) % 2) == 1;
            logic [31:0] e = {o, 1'b0, 27'd0, di, u};
            wr('h100 + 8*p, e | 32'h4000_FF30);
            rd('h100 + 8*p, v); check("R3 readback", v, e);
            check("R5 pad_out", 32'(pad_out[p]), 32'(o));
            check("R5 pad_oe", 32'(pad_oe[p]), 32'(u == 2'd1 && !di));
        end

        // R4: second word and pull outputs
        for (int p = 0; p < NP; p++) begin
            logic [1:0] pl = 2'((p + 1) % 4);
            wr('h104 + 8*p, {29'h1FFF_FFF8 >> 3, 1'b1, pl} | 32'hF0F0_0000);
            rd('h104 + 8*p, v); check("R4 readback", v, {29'd0, 1'b1, pl});
            check("R4 pull_sel", 32'(pull_sel[2*p +: 2]), 32'(pl));
        end

        // R6 R7: synchronizer latency and sense gating
        for (int j = 0; j < 3; j++) begin
            int p = (j == 0) ? 0 : ((j == 1) ? 40 : NP - 1);
            wr('h104 + 8*p, 32'h0);
            @(negedge clk); pad_in[p] = 1'b1;
            @(negedge clk); rd('h100 + 8*p, v); check("R6 one edge", 32'(v[30]), 32'd0);
            @(negedge clk); rd('h100 + 8*p, v); check("R6 two edges", 32'(v[30]), 32'd1);
            wr('h100 + 8*p, 32'h0000_0005);
            rd('h100 + 8*p, v); check("R6 ro bit", v, 32'h4000_0005);
            wr('h104 + 8*p, 32'h4);
            rd('h100 + 8*p, v); check("R7 gated", 32'(v[30]), 32'd0);
            pad_in[p] = 1'b0;
        end

        // R8: unmapped offsets
        wr('h100, 32'h8000_0001);
        wr('h0C, 32'hFFFFFFFF);  rd('h0C, v);  check("R8 gap", v, 32'h0);
        wr('h7C, 32'hFFFFFFFF);  rd('h7C, v);  check("R8 gap2", v, 32'h0);
        wr('h100 + 8*NP, 32'hFFFFFFFF); rd('h100 + 8*NP, v); check("R8 past end", v, 32'h0);
        wr('h102, 32'h0000_0004); rd('h102, v); check("R8 misaligned", v, 32'h0);
        rd('h100, v); check("R8 pin0 intact", v, 32'h8000_0001);
        rd('h00, v);  check("R8 bitmap intact", v, 32'h0);
        rd('h08, v);  check("R8 bitmap2 intact", v, 32'h7FFFFFFF);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule